// File: doc/BRIEF.md
# Bit-Slip Word Boundary Aligner

This block shifts where word boundaries fall in a parallel receive or transmit data path, one bit position at a time. On the receive side, each rising edge of a slip control input discards the oldest bit still waiting in the stream. Every later output word therefore begins one serial bit further along. The current receive offset is reported on a status output. The offset wraps to zero after width minus one. At the wrap, one output word is withheld so that the stream moves on by whole bits and no data is repeated. Such a block usually sits after a deserializer, under a controller that issues slips until a known pattern shows up in place.

On the transmit side, outgoing words are delayed by a bit count taken from a select input. The bits that emerge before the first word are zero. Both paths work on a parallel word of 10 or 20 bits, set by a parameter. Each path carries a valid strobe. Bit 0 of every word is the earliest bit in serial order.

Top module: `bitslip_aligner`

## Requirements
- R1: With parameter W (10 or 20) and receive offset k, the output word for input word number m (counted from 0 since reset, valid words only) holds stream bits m*W-W+k through m*W+k-1, with stream bit m*W+j being bit j of input word m. The output is registered one cycle after the input word's valid cycle, and word 0 produces no output.
- R2: A rising edge of `rx_slip` (high now, low in the previous cycle) raises the receive offset by exactly one. Holding `rx_slip` high for further cycles changes nothing.
- R3: A word accepted in the same cycle as a slip edge still uses the old offset. The next accepted word uses the new offset, so its output starts one stream bit later.
- R4: A slip edge at offset W-1 sets the offset to 0, and the next accepted receive word produces no output word. Output then resumes with no stream bit repeated or skipped.
- R5: `rx_offset` always shows the current receive offset, in the range 0 to W-1.
- R6: When `tx_valid` is high, the next cycle shows `tx_out_valid` high and a `tx_out_data` in which bit j equals transmit stream bit n*W+j-s. Here n is the word number since reset and s is `tx_sel`, clamped to W-1. Stream bits before word 0 are zero.
- R7: `tx_sel` and `tx_data` are read only when `tx_valid` is high. In the cycle after `tx_valid` is low, `tx_out_valid` is low and `tx_out_data` holds its value.
- R8: In the cycle after `rx_valid` is low, `rx_out_valid` is low and `rx_out_data` holds its value.
- R9: A synchronous reset `rst` sets the receive offset to 0, clears all data history and both valid outputs, and clears the edge detector. An `rx_slip` already high when reset is released therefore counts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Receive input word strobe |
| rx_data | input | W | Receive input word, bit 0 earliest |
| rx_slip | input | 1 | Slip request, acts on its rising edge |
| rx_out_valid | output | 1 | Aligned receive word strobe |
| rx_out_data | output | W | Aligned receive word |
| rx_offset | output | $clog2(W) | Current receive slip offset |
| tx_valid | input | 1 | Transmit input word strobe |
| tx_data | input | W | Transmit input word, bit 0 earliest |
| tx_sel | input | $clog2(W) | Transmit delay in bits |
| tx_out_valid | output | 1 | Delayed transmit word strobe |
| tx_out_data | output | W | Delayed transmit word |

## Verification
The bench holds `rx_slip` high across several cycles, including cycles that carry data. A design that detected levels instead of edges would keep moving the boundary. The bench also issues a slip in the same cycle as a word. A design that applied the new offset too early would show a one-bit shift one word too soon. It slips W times to force the wrap. A design that did not withhold a word there would repeat W-1 bits of the stream. It holds `rx_slip` high through reset to check that a cleared edge detector sees one slip at release. On the transmit side it uses delays of zero, the maximum, and an out-of-range value, and it changes the select while the strobe is low. A wrong clamp, a wrong window direction, or sampling the select outside valid cycles would all corrupt the delayed words.

// File: rtl/bitslip_aligner.sv
module bitslip_aligner #(
  parameter int W = 10,
  localparam int OW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [W-1:0]  rx_data,
  input  logic          rx_slip,
  output logic          rx_out_valid,
  output logic [W-1:0]  rx_out_data,
  output logic [OW-1:0] rx_offset,
  input  logic          tx_valid,
  input  logic [W-1:0]  tx_data,
  input  logic [OW-1:0] tx_sel,
  output logic          tx_out_valid,
  output logic [W-1:0]  tx_out_data
);
  localparam logic [OW-1:0] KMAX = OW'(W - 1);
  localparam logic [OW:0]   WIDE = (OW+1)'(W);

  logic [W-1:0] rx_prev, tx_prev;
  logic slip_q, primed, skip;

  wire slip_edge = rx_slip & ~slip_q;
  wire wrap      = slip_edge && (rx_offset == KMAX);

  wire [2*W-1:0] rx_win = {rx_data, rx_prev} >> rx_offset;

  wire [OW-1:0]  tx_k   = (tx_sel > KMAX) ? KMAX : tx_sel;
  wire [OW:0]    tx_sh  = WIDE - {1'b0, tx_k};
  wire [2*W-1:0] tx_win = {tx_data, tx_prev} >> tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      slip_q       <= 1'b0;
      rx_offset    <= '0;
      skip         <= 1'b0;
      primed       <= 1'b0;
      rx_prev      <= '0;
      rx_out_valid <= 1'b0;
      rx_out_data  <= '0;
    end else begin
      slip_q <= rx_slip;
      if (slip_edge) rx_offset <= wrap ? '0 : rx_offset + 1'b1;
      if (wrap)          skip <= 1'b1;
      else if (rx_valid) skip <= 1'b0;
      rx_out_valid <= rx_valid && primed && !skip;
      if (rx_valid) begin
        primed      <= 1'b1;
        rx_prev     <= rx_data;
        rx_out_data <= rx_win[W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_prev      <= '0;
      tx_out_valid <= 1'b0;
      tx_out_data  <= '0;
    end else begin
      tx_out_valid <= tx_valid;
      if (tx_valid) begin
        tx_prev     <= tx_data;
        tx_out_data <= tx_win[W-1:0];
      end
    end
  end

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (rx_offset == '0) && !rx_out_valid && !tx_out_valid);

  p_range_r5: assert property (@(posedge clk) disable iff (rst)
    rx_offset <= KMAX);

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_slip && !slip_q && rx_offset != KMAX) |=> rx_offset == $past(rx_offset) + 1'b1);

  p_level_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_slip && slip_q) |=> $stable(rx_offset));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_slip && !slip_q && rx_offset == KMAX) |=> (rx_offset == '0) && skip);

  p_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (skip && rx_valid) |=> !rx_out_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !rx_out_valid && $stable(rx_out_data));

  p_txhold_r7: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |=> !tx_out_valid && $stable(tx_out_data));

  p_txvalid_r6: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> tx_out_valid);
endmodule

// File: tb/tb_bitslip_aligner.sv
module tb_bitslip_aligner;
  localparam int CLK = 10;
  localparam int W   = 10;
  localparam int OW  = $clog2(W);

  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 1'b0, rx_slip = 1'b0, tx_valid = 1'b0;
  logic [W-1:0] rx_data = '0, tx_data = '0;
  logic [OW-1:0] tx_sel = '0;
  logic rx_out_valid, tx_out_valid;
  logic [W-1:0] rx_out_data, tx_out_data;
  logic [OW-1:0] rx_offset;

  int checks = 0, errors = 0;
  int rseed, tseed, m, k, n;
  bit skip, primed, pslip;

  always #(CLK/2) clk = ~clk;

  bitslip_aligner #(.W(W)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_slip(rx_slip),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_offset(rx_offset),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sel(tx_sel),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data));

  function automatic logic sb(int seed, int i);
    int unsigned h;
    if (i < 0) return 1'b0;
    h = (i + seed) * 32'd2654435761;
    h = h ^ (h >> 15);
    return h[9];
  endfunction

  function automatic logic [W-1:0] word(int seed, int base);
    logic [W-1:0] w;
    for (int j = 0; j < W; j++) w[j] = sb(seed, base + j);
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic slip_level);
    @(negedge clk);
    rst = 1'b1; rx_valid = 1'b0; tx_valid = 1'b0; rx_slip = slip_level;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m = 0; k = 0; n = 0; skip = 0; primed = 0; pslip = 0;
  endtask

  task automatic rstep(logic rv, logic rs, string tag);
    logic ev;
    logic [W-1:0] ed, held;
    held = rx_out_data;
    ev = 1'b0; ed = '0;
    rx_valid = rv; rx_slip = rs;
    rx_data = rv ? word(rseed, m * W) : W'(10'h2b5);
    if (rv) begin
      ev = primed && !skip;
      ed = word(rseed, m * W - W + k);
      primed = 1; skip = 0; m++;
    end
    if (rs && !pslip) begin
      if (k == W - 1) begin k = 0; skip = 1; end
      else k++;
    end
    pslip = rs;
    @(posedge clk); @(negedge clk);
    chk({tag, " valid"}, 32'(rx_out_valid), 32'(ev));
    if (ev) chk({tag, " data"}, 32'(rx_out_data), 32'(ed));
    else if (!rv) chk({tag, " hold R8"}, 32'(rx_out_data), 32'(held));
    chk({tag, " offset R5"}, 32'(rx_offset), 32'(k));
  endtask

  task automatic tstep(logic tv, int sel, string tag);
    logic [W-1:0] ed, held;
    int s;
    held = tx_out_data;
    tx_valid = tv; tx_sel = OW'(sel);
    s = (sel > W - 1) ? W - 1 : sel;
    tx_data = tv ? word(tseed, n * W) : W'(10'h155);
    ed = tv ? word(tseed, n * W - s) : held;
    if (tv) n++;
    @(posedge clk); @(negedge clk);
    chk({tag, " valid"}, 32'(tx_out_valid), 32'(tv));
    chk({tag, " data"}, 32'(tx_out_data), 32'(ed));
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R9 reset offset", 32'(rx_offset), 0);
    chk("R9 reset rx valid", 32'(rx_out_valid), 0);
    chk("R9 reset tx valid", 32'(tx_out_valid), 0);
  endtask

  task automatic t_rx_plain(int seed);
    rseed = seed;
    do_reset(1'b0);
    for (int i = 0; i < 6; i++) rstep(1, 0, "R1 plain");
    rstep(0, 0, "R8 idle");
    rstep(0, 0, "R8 idle");
    for (int i = 0; i < 3; i++) rstep(1, 0, "R1 resume");
  endtask

  task automatic t_rx_slip;
    rseed = 77;
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) rstep(1, 0, "R1 pre");
    rstep(0, 1, "R2 edge idle");
    rstep(1, 1, "R2 level held");
    rstep(1, 1, "R2 level held");
    rstep(1, 0, "R3 after");
    rstep(1, 1, "R3 same cycle");
    rstep(1, 0, "R3 next word");
    rstep(1, 0, "R3 next word");
    rstep(0, 0, "R8 idle");
  endtask

  task automatic t_wrap;
    rseed = 5;
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) rstep(1, 0, "R1 pre");
    for (int i = 0; i < W - 1; i++) begin
      rstep(0, 1, "R2 pulse");
      rstep(1, 0, "R3 shifted");
    end
    chk("R4 at max", 32'(rx_offset), 32'(W - 1));
    rstep(0, 1, "R4 wrap edge");
    rstep(1, 0, "R4 suppressed");
    for (int i = 0; i < 4; i++) rstep(1, 0, "R4 continue");
    rstep(1, 1, "R2 edge with data");
    rstep(1, 0, "R3 after data edge");
  endtask

  task automatic t_reset_slip_high;
    rseed = 9;
    do_reset(1'b1);
    pslip = 0;
    rstep(1, 1, "R9 edge at release");
    rstep(1, 1, "R9 held");
    rstep(1, 0, "R9 data");
  endtask

  task automatic t_tx;
    tseed = 31;
    do_reset(1'b0);
    tstep(1, 0, "R6 sel0");
    tstep(1, 0, "R6 sel0");
    tstep(1, 3, "R6 sel3");
    tstep(1, 3, "R6 sel3");
    tstep(0, 7, "R7 idle sel change");
    tstep(0, 1, "R7 idle sel change");
    tstep(1, 3, "R6 sel3 after idle");
    tstep(1, W - 1, "R6 max");
    tstep(1, W - 1, "R6 max");
    tstep(1, 15, "R6 clamp");
    tstep(1, 1, "R6 sel1");
    tseed = 1234;
    do_reset(1'b0);
    tstep(1, 5, "R6 first word zeros");
    tstep(1, 5, "R6 sel5");
  endtask

  initial begin
    #(CLK * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rx_plain(1);
    t_rx_plain(400);
    t_rx_slip();
    t_wrap();
    t_reset_slip_high();
    t_tx();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule